// File: doc/BRIEF.md
# Pad drive-strength compensation scheduler

This block decides when the output drivers of a high-speed parallel bus interface get new drive-strength codes. It asks an external measurement engine for a fresh pair of pull-up (P) and pull-down (N) codes. It holds each answer in shadow registers and moves the answer onto the pads only in a cycle where the bus reports that it is idle. This means a code change never lands in the middle of a transfer.

Software uses a small register port to choose between two modes. In periodic mode, measurements repeat at an interval of (count+1) ticks of a prescaled base tick. In one-shot mode, a single measurement runs, and when it finishes, further automatic updates stop. The data/control pad group and the strobe pad group can each be bypassed, so that their codes come from software override values instead of measured ones. When both groups are bypassed, periodic scheduling is turned off completely. The P and N readback always shows the codes that are currently driving the data/control group.

Top module: `pad_comp_sched`

## Requirements
- R1: After reset, all four pad code outputs are mid-scale (8 for 4-bit codes). The control word reads 0, the P/N readback (address 2) reads 0x88, and `meas_start` is low.
- R2: Control word at address 0 has these fields:
  - bits [3:0]: interval count q
  - bit 4: periodic enable
  - bit 5: one-shot command
  - bit 6: 3.3 V select
  - bit 7: data-group bypass
  - bit 8: strobe-group bypass

  With periodic enable set, `meas_start` pulses for exactly one cycle. Consecutive pulses are (q+1)*PRESCALE cycles apart.
- R3: The P/N codes returned with `meas_done` reach the pad outputs only after a cycle in which `bus_idle` is high. While `bus_idle` stays low, the pad codes keep their previous values. Codes are applied in the order they were measured.
- R4: Writing bit 5 = 1 with bit 6 = 0 starts one measurement. Bit 5 reads back as 1 until that measurement's codes have been applied, and then reads 0.
- R5: When a one-shot cycle completes, the periodic enable clears to 0. No further `meas_start` occurs until software sets it again.
- R6: A one-shot write with bit 6 = 1 is ignored. Bit 5 stays 0 and no measurement starts.
- R7: With both bypass bits set, no periodic measurement starts, even when periodic enable is set.
- R8: Address 1 holds the software override codes:
  - [3:0]: data P
  - [7:4]: data N
  - [11:8]: strobe P
  - [15:12]: strobe N

  A group whose bypass bit is set drives its override codes. A group whose bypass bit is clear drives the last applied measured codes.
- R9: Address 2 reads the data/control group codes, with P in [3:0] and N in [7:4]. These are the codes actually driven, including any override. The strobe codes are never reported here.
- R10: A one-shot command written while a periodic measurement is in flight waits for that measurement to finish and then runs its own measurement. This gives two separate `meas_start` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 overrides, 2 P/N readback) |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for `reg_addr` |
| meas_start | output | 1 | One-cycle request to the measurement engine |
| meas_done | input | 1 | Engine reply strobe, qualifies `meas_p`/`meas_n` |
| meas_p | input | CODE_W | Measured pull-up code |
| meas_n | input | CODE_W | Measured pull-down code |
| bus_idle | input | 1 | High when a code change cannot disturb bus traffic |
| pad_dat_p | output | CODE_W | P code for data/control pads |
| pad_dat_n | output | CODE_W | N code for data/control pads |
| pad_stb_p | output | CODE_W | P code for strobe pads |
| pad_stb_n | output | CODE_W | N code for strobe pads |

## Verification
A wrong sequencer state shows up at `meas_start` within one measurement interval. Such a state might be a lost one-shot request, a stale periodic request, or a periodic enable that survives a one-shot. The symptom is a missing pulse, an extra pulse, or a pulse-to-pulse gap that differs from (q+1)*PRESCALE. A shadow or apply fault shows on the pad code outputs as soon as the next `bus_idle` cycle follows a `meas_done`: the codes either change while the bus is busy or come out of order. Bypass or readback faults are visible right away on the pad outputs and on address 2.

// File: rtl/comp_pkg.sv
package comp_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_START,
    SEQ_WAIT,
    SEQ_APPLY
  } seq_state_t;

  // Cycles between two scheduled measurements for interval count q.
  function automatic int unsigned interval_cycles(input int unsigned q, input int unsigned pre);
    return (q + 1) * pre;
  endfunction

  // Mid-scale code loaded at reset.
  function automatic int unsigned mid_code(input int unsigned w);
    return 1 << (w - 1);
  endfunction

endpackage

// File: rtl/comp_interval_timer.sv
module comp_interval_timer #(
  parameter int Q_W      = 4,
  parameter int PRESCALE = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           restart,
  input  logic [Q_W-1:0] qcnt,
  output logic           fire
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int GAP_W = $clog2(PRESCALE * (1 << Q_W)) + 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [Q_W-1:0]   ival_cnt;
  logic             base_tick;
  logic             last_tick;

  assign base_tick = (pre_cnt == PRE_W'(PRESCALE - 1));
  assign last_tick = base_tick && (ival_cnt == qcnt);
  assign fire      = run && !restart && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      ival_cnt <= '0;
    end else if (!run || restart) begin
      pre_cnt  <= '0;
      ival_cnt <= '0;
    end else if (base_tick) begin
      pre_cnt  <= '0;
      ival_cnt <= last_tick ? '0 : ival_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // Independent cycle counter used only to check the interval length.
  logic [GAP_W-1:0] gap_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         gap_cnt <= '0;
    else if (!run || restart || fire)   gap_cnt <= '0;
    else                                gap_cnt <= gap_cnt + 1'b1;
  end

  // R2
  interval_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> gap_cnt == GAP_W'(comp_pkg::interval_cycles(32'(qcnt), PRESCALE) - 1));

endmodule

// File: rtl/comp_regs.sv
module comp_regs #(
  parameter int Q_W    = 4,
  parameter int CODE_W = 4,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              os_done,
  input  logic [CODE_W-1:0] rb_p,
  input  logic [CODE_W-1:0] rb_n,
  output logic [Q_W-1:0]    qcnt,
  output logic              per_en,
  output logic              byp_dat,
  output logic              byp_stb,
  output logic [CODE_W-1:0] ovr_dp,
  output logic [CODE_W-1:0] ovr_dn,
  output logic [CODE_W-1:0] ovr_sp,
  output logic [CODE_W-1:0] ovr_sn,
  output logic              ctrl_wr,
  output logic              os_set,
  output logic              os_busy
);
  localparam int F_PER = Q_W;
  localparam int F_OS  = Q_W + 1;
  localparam int F_S33 = Q_W + 2;
  localparam int F_BD  = Q_W + 3;
  localparam int F_BS  = Q_W + 4;
  localparam logic [CODE_W-1:0] MID = CODE_W'(comp_pkg::mid_code(CODE_W));

  logic sel33;
  logic ovr_wr;

  assign ctrl_wr = reg_wr && (reg_addr == 2'd0);
  assign ovr_wr  = reg_wr && (reg_addr == 2'd1);
  assign os_set  = ctrl_wr && reg_wdata[F_OS] && !reg_wdata[F_S33] && !os_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt    <= '0;
      sel33   <= 1'b0;
      byp_dat <= 1'b0;
      byp_stb <= 1'b0;
      per_en  <= 1'b0;
      os_busy <= 1'b0;
      ovr_dp  <= MID;
      ovr_dn  <= MID;
      ovr_sp  <= MID;
      ovr_sn  <= MID;
    end else begin
      if (ctrl_wr) begin
        qcnt    <= reg_wdata[Q_W-1:0];
        sel33   <= reg_wdata[F_S33];
        byp_dat <= reg_wdata[F_BD];
        byp_stb <= reg_wdata[F_BS];
      end
      if (os_done)      per_en <= 1'b0;
      else if (ctrl_wr) per_en <= reg_wdata[F_PER];
      if (os_done)      os_busy <= 1'b0;
      else if (os_set)  os_busy <= 1'b1;
      if (ovr_wr) begin
        ovr_dp <= reg_wdata[CODE_W-1:0];
        ovr_dn <= reg_wdata[2*CODE_W-1:CODE_W];
        ovr_sp <= reg_wdata[3*CODE_W-1:2*CODE_W];
        ovr_sn <= reg_wdata[4*CODE_W-1:3*CODE_W];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[Q_W-1:0] = qcnt;
        reg_rdata[F_PER]   = per_en;
        reg_rdata[F_OS]    = os_busy;
        reg_rdata[F_S33]   = sel33;
        reg_rdata[F_BD]    = byp_dat;
        reg_rdata[F_BS]    = byp_stb;
      end
      2'd1: begin
        reg_rdata[CODE_W-1:0]          = ovr_dp;
        reg_rdata[2*CODE_W-1:CODE_W]   = ovr_dn;
        reg_rdata[3*CODE_W-1:2*CODE_W] = ovr_sp;
        reg_rdata[4*CODE_W-1:3*CODE_W] = ovr_sn;
      end
      2'd2: begin
        reg_rdata[CODE_W-1:0]        = rb_p;
        reg_rdata[2*CODE_W-1:CODE_W] = rb_n;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R4
  os_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(os_busy) |-> $past(os_done));

  // R5
  rearm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    os_done |=> !per_en);

endmodule

// File: rtl/comp_seq_fsm.sv
module comp_seq_fsm #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              per_run,
  input  logic              os_set,
  input  logic              meas_done,
  input  logic [CODE_W-1:0] meas_p,
  input  logic [CODE_W-1:0] meas_n,
  input  logic              bus_idle,
  output logic              meas_start,
  output logic [CODE_W-1:0] app_p,
  output logic [CODE_W-1:0] app_n,
  output logic              apply_evt,
  output logic              os_done,
  output logic              kind_os
);
  import comp_pkg::*;
  localparam logic [CODE_W-1:0] MID = CODE_W'(mid_code(CODE_W));

  seq_state_t        state;
  logic              os_pend;
  logic              per_pend;
  logic              take_os;
  logic              take_per;
  logic [CODE_W-1:0] sh_p;
  logic [CODE_W-1:0] sh_n;

  assign take_os    = (state == SEQ_IDLE) && os_pend;
  assign take_per   = (state == SEQ_IDLE) && !os_pend && per_run && (per_pend || fire);
  assign meas_start = (state == SEQ_START);
  assign apply_evt  = (state == SEQ_APPLY) && bus_idle;
  assign os_done    = apply_evt && kind_os;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      kind_os  <= 1'b0;
      os_pend  <= 1'b0;
      per_pend <= 1'b0;
      sh_p     <= MID;
      sh_n     <= MID;
      app_p    <= MID;
      app_n    <= MID;
    end else begin
      if (take_os)     os_pend <= 1'b0;
      else if (os_set) os_pend <= 1'b1;

      if (!per_run || take_per) per_pend <= 1'b0;
      else if (fire)            per_pend <= 1'b1;

      case (state)
        SEQ_IDLE: begin
          if (take_os) begin
            state   <= SEQ_START;
            kind_os <= 1'b1;
          end else if (take_per) begin
            state   <= SEQ_START;
            kind_os <= 1'b0;
          end
        end
        SEQ_START: state <= SEQ_WAIT;
        SEQ_WAIT: begin
          if (meas_done) begin
            sh_p  <= meas_p;
            sh_n  <= meas_n;
            state <= SEQ_APPLY;
          end
        end
        SEQ_APPLY: begin
          if (bus_idle) begin
            app_p <= sh_p;
            app_n <= sh_n;
            state <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start |=> !meas_start);

  // R3
  defer_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(app_p) || !$stable(app_n)) |-> $past(bus_idle));

endmodule

// File: rtl/pad_comp_sched.sv
module pad_comp_sched #(
  parameter int Q_W      = 4,
  parameter int CODE_W   = 4,
  parameter int REG_W    = 16,
  parameter int PRESCALE = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              meas_start,
  input  logic              meas_done,
  input  logic [CODE_W-1:0] meas_p,
  input  logic [CODE_W-1:0] meas_n,
  input  logic              bus_idle,
  output logic [CODE_W-1:0] pad_dat_p,
  output logic [CODE_W-1:0] pad_dat_n,
  output logic [CODE_W-1:0] pad_stb_p,
  output logic [CODE_W-1:0] pad_stb_n
);
  logic [Q_W-1:0]    qcnt;
  logic              per_en, byp_dat, byp_stb;
  logic [CODE_W-1:0] ovr_dp, ovr_dn, ovr_sp, ovr_sn;
  logic              ctrl_wr, os_set, os_busy;
  logic              os_done, apply_evt, kind_os;
  logic              per_run, fire, both_byp, per_start;
  logic [CODE_W-1:0] app_p, app_n;

  assign both_byp  = byp_dat && byp_stb;
  assign per_run   = per_en && !both_byp;
  assign per_start = meas_start && !kind_os;

  comp_regs #(.Q_W(Q_W), .CODE_W(CODE_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .os_done(os_done),
    .rb_p(pad_dat_p), .rb_n(pad_dat_n), .qcnt(qcnt), .per_en(per_en),
    .byp_dat(byp_dat), .byp_stb(byp_stb), .ovr_dp(ovr_dp), .ovr_dn(ovr_dn),
    .ovr_sp(ovr_sp), .ovr_sn(ovr_sn), .ctrl_wr(ctrl_wr), .os_set(os_set),
    .os_busy(os_busy)
  );

  comp_interval_timer #(.Q_W(Q_W), .PRESCALE(PRESCALE)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(per_run), .restart(ctrl_wr),
    .qcnt(qcnt), .fire(fire)
  );

  comp_seq_fsm #(.CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .per_run(per_run), .os_set(os_set),
    .meas_done(meas_done), .meas_p(meas_p), .meas_n(meas_n), .bus_idle(bus_idle),
    .meas_start(meas_start), .app_p(app_p), .app_n(app_n), .apply_evt(apply_evt),
    .os_done(os_done), .kind_os(kind_os)
  );

  assign pad_dat_p = byp_dat ? ovr_dp : app_p;
  assign pad_dat_n = byp_dat ? ovr_dn : app_n;
  assign pad_stb_p = byp_stb ? ovr_sp : app_p;
  assign pad_stb_n = byp_stb ? ovr_sn : app_n;

  // R7
  bypass_no_sched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    both_byp |=> !per_start);

  // R4
  os_busy_until_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (os_busy && !apply_evt) |=> os_busy);

endmodule

// File: tb/tb_pad_comp_sched.sv
module tb_pad_comp_sched;
  localparam int PRE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        meas_start;
  logic        meas_done = 1'b0;
  logic [3:0]  meas_p = '0, meas_n = '0;
  logic        bus_idle = 1'b1;
  logic [3:0]  pad_dat_p, pad_dat_n, pad_stb_p, pad_stb_n;

  pad_comp_sched #(.PRESCALE(PRE)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .meas_start(meas_start),
    .meas_done(meas_done), .meas_p(meas_p), .meas_n(meas_n), .bus_idle(bus_idle),
    .pad_dat_p(pad_dat_p), .pad_dat_n(pad_dat_n), .pad_stb_p(pad_stb_p),
    .pad_stb_n(pad_stb_n)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, start_cnt = 0, done_cnt = 0, seq = 0;
  bit finished = 1'b0, mon_on = 1'b1;
  logic [7:0] exp_q[$];
  int st_cyc[$];
  logic [7:0] last_app = 8'h88, prev_dat = 8'h88;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Control word: [3:0] q, 4 periodic, 5 one-shot, 6 3.3V, 7 data bypass, 8 strobe bypass
  function automatic logic [15:0] ctl(input int q, input bit per, input bit os,
                                      input bit s33, input bit bd, input bit bs);
    return {7'd0, bs, bd, s33, os, per, 4'(q)};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_os_clear();
    logic [15:0] v;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      rd(2'd0, v);
      if (!v[5]) break;
    end
  endtask

  // Measurement engine model, the driver side of the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && meas_start) begin
        start_cnt++;
        st_cyc.push_back(cyc);
        repeat (2) @(negedge clk);
        meas_p = 4'(seq * 3 + 1);
        meas_n = 4'(seq * 5 + 2);
        seq++;
        exp_q.push_back({meas_p, meas_n});
        meas_done = 1'b1;
        @(negedge clk);
        meas_done = 1'b0;
        done_cnt++;
      end
    end
  end

  // Monitor: every change of the data group codes must be the next measured pair.
  always @(negedge clk) begin
    logic [7:0] cur, e;
    if (rst_n) begin
      cur = {pad_dat_p, pad_dat_n};
      if (mon_on && cur != prev_dat) begin
        if (exp_q.size() == 0) check(1'b0, "R3 apply without measurement", cur, 0);
        else begin
          e = exp_q.pop_front();
          check(cur == e, "R3 applied codes in order", cur, e);
          check({pad_stb_p, pad_stb_n} == e, "R8 strobe follows measured", {pad_stb_p, pad_stb_n}, e);
          last_app = e;
        end
      end
      prev_dat = cur;
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    int s, s0;
    logic [7:0] hold;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({pad_dat_p, pad_dat_n, pad_stb_p, pad_stb_n} == 16'h8888, "R1 reset pad codes",
          {pad_dat_p, pad_dat_n, pad_stb_p, pad_stb_n}, 16'h8888);
    rd(2'd0, v); check(v == 16'h0, "R1 control reset", v, 0);
    rd(2'd2, v); check(v == 16'h88, "R1 readback reset", v, 16'h88);
    check(meas_start == 1'b0, "R1 no start", meas_start, 0);

    // R4 one-shot
    wr(2'd0, ctl(0, 0, 1, 0, 0, 0));
    rd(2'd0, v); check(v[5] == 1'b1, "R4 one-shot busy", v[5], 1);
    wait_os_clear();
    rd(2'd0, v); check(v[5] == 1'b0, "R4 one-shot cleared", v[5], 0);
    check(start_cnt == 1, "R4 single measurement", start_cnt, 1);
    check({pad_dat_p, pad_dat_n} == last_app && last_app == 8'h12, "R4 codes applied",
          {pad_dat_p, pad_dat_n}, 8'h12);
    s = start_cnt;
    repeat (200) @(negedge clk);
    check(start_cnt == s, "R5 frozen after one-shot", start_cnt, s);

    // R6 one-shot with 3.3 V select is ignored
    wr(2'd0, ctl(0, 0, 1, 1, 0, 0));
    rd(2'd0, v); check(v[5] == 1'b0, "R6 one-shot ignored bit", v[5], 0);
    repeat (50) @(negedge clk);
    check(start_cnt == s, "R6 no measurement", start_cnt, s);

    // R3 deferral while bus busy
    bus_idle = 1'b0;
    hold = {pad_dat_p, pad_dat_n};
    s0 = done_cnt;
    wr(2'd0, ctl(0, 0, 1, 0, 0, 0));
    for (int i = 0; i < 100 && done_cnt == s0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    check({pad_dat_p, pad_dat_n} == hold, "R3 held while busy", {pad_dat_p, pad_dat_n}, hold);
    rd(2'd0, v); check(v[5] == 1'b1, "R3 one-shot pending apply", v[5], 1);
    bus_idle = 1'b1;
    wait_os_clear();
    check({pad_dat_p, pad_dat_n} == 8'h47, "R3 applied after idle", {pad_dat_p, pad_dat_n}, 8'h47);

    // R2 periodic intervals, q=1 and q=0
    st_cyc.delete();
    wr(2'd0, ctl(1, 1, 0, 0, 0, 0));
    for (int i = 0; i < 300 && st_cyc.size() < 4; i++) @(negedge clk);
    for (int k = 1; k < 4; k++)
      check(st_cyc.size() >= 4 && st_cyc[k] - st_cyc[k-1] == 2 * PRE, "R2 interval q=1",
            st_cyc.size() >= 4 ? st_cyc[k] - st_cyc[k-1] : -1, 2 * PRE);
    st_cyc.delete();
    wr(2'd0, ctl(0, 1, 0, 0, 0, 0));
    for (int i = 0; i < 300 && st_cyc.size() < 3; i++) @(negedge clk);
    for (int k = 1; k < 3; k++)
      check(st_cyc.size() >= 3 && st_cyc[k] - st_cyc[k-1] == PRE, "R2 interval q=0",
            st_cyc.size() >= 3 ? st_cyc[k] - st_cyc[k-1] : -1, PRE);
    wr(2'd0, ctl(0, 0, 0, 0, 0, 0));
    repeat (20) @(negedge clk);

    // R10 one-shot during a periodic measurement
    wr(2'd0, ctl(3, 1, 0, 0, 0, 0));
    s0 = start_cnt;
    for (int i = 0; i < 200 && start_cnt == s0; i++) @(negedge clk);
    wr(2'd0, ctl(3, 1, 1, 0, 0, 0));
    for (int i = 0; i < 100 && start_cnt < s0 + 2; i++) @(negedge clk);
    check(done_cnt >= s0 + 1, "R10 one-shot after running cycle", done_cnt, s0 + 1);
    repeat (40) @(negedge clk);
    check(start_cnt == s0 + 2, "R10 two measurements", start_cnt, s0 + 2);
    rd(2'd0, v); check(v[4] == 1'b0, "R5 periodic disabled", v[4], 0);
    check(exp_q.size() == 0, "R3 all measured applied", exp_q.size(), 0);

    // R7, R8, R9 bypass
    mon_on = 1'b0;
    wr(2'd1, 16'h4321);
    wr(2'd0, ctl(0, 1, 0, 0, 1, 1));
    s = start_cnt;
    repeat (100) @(negedge clk);
    check(start_cnt == s, "R7 no periodic when both bypassed", start_cnt, s);
    check({pad_dat_p, pad_dat_n, pad_stb_p, pad_stb_n} == 16'h1234, "R8 both overrides",
          {pad_dat_p, pad_dat_n, pad_stb_p, pad_stb_n}, 16'h1234);
    rd(2'd2, v); check(v == 16'h21, "R9 readback overridden data", v, 16'h21);
    wr(2'd0, ctl(0, 0, 0, 0, 0, 1));
    check({pad_dat_p, pad_dat_n} == last_app, "R8 data measured", {pad_dat_p, pad_dat_n}, last_app);
    check({pad_stb_p, pad_stb_n} == 8'h34, "R8 strobe override", {pad_stb_p, pad_stb_n}, 8'h34);
    rd(2'd2, v); check(v == {8'h0, last_app[3:0], last_app[7:4]}, "R9 readback excludes strobe",
                       v, {8'h0, last_app[3:0], last_app[7:4]});
    finish_run();
  end
endmodule